// File: doc/BRIEF.md
# Turn-Model Mesh Route Computation Unit

This block picks the output port of one router in a two-dimensional mesh for an arriving packet. It compares the router's own coordinates with the destination coordinates carried in a head flit. It then returns a one-hot choice among the four neighbour ports and the local ejection port. The route is worked out once per packet, on the head flit, and is held in a register for the body and tail flits that follow.

A static mode input selects the routing scheme. The first scheme is strict dimension order: the packet finishes X first, then Y. The other three schemes are turn-restricted adaptive variants: west-first, north-last and negative-first. Each of these forbids only one turn in each of the two turn cycles, so it can leave two productive ports open to a packet. When two ports are open, a selector compares the free downstream buffer slots reported for each of them and picks one. Only minimal routes are ever produced.

Top module: `mesh_route_unit`

## Requirements
- R1: While reset is asserted, and after it is released until the first head flit arrives, `route_vld` is 0 and `route_port` is all zeros.
- R2: A head flit whose destination equals the current node gets `route_port` = 5'b00001, the Local port.
- R3: A head flit sampled at a clock edge yields `route_vld` = 1 after that edge, with exactly one bit of `route_port` set. The bit order is Local = bit 0, East = bit 1, West = bit 2, North = bit 3, South = bit 4. A cycle with no head flit gives `route_vld` = 0 and leaves `route_port` unchanged.
- R4: Every chosen port is productive. East requires the destination X to be greater than the current X, West requires it to be smaller, North requires the destination Y to be greater, and South requires it to be smaller.
- R5: With `route_mode` = 0 (dimension order), East or West is chosen while the X coordinates differ. North or South is chosen only after they match.
- R6: With `route_mode` = 1 (west-first), West is chosen whenever the destination lies to the west, and never otherwise. In the other cases any productive East, North or South port may be chosen.
- R7: With `route_mode` = 2 (north-last), North is chosen only when the X coordinates already match. A packet that needs to go north and is still off in X gets its X port.
- R8: With `route_mode` = 3 (negative-first), West or South is chosen whenever either of them is productive. East or North is chosen only when neither West nor South is productive.
- R9: When the mode permits both a productive X port and a productive Y port, the Y port is chosen only if its free-slot count is strictly greater. A tie goes to the X port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_vld | input | 1 | A head flit with a destination is present this cycle |
| here_x | input | CW | X coordinate of this router |
| here_y | input | CW | Y coordinate of this router |
| dest_x | input | CW | Destination X from the head flit |
| dest_y | input | CW | Destination Y from the head flit |
| route_mode | input | 2 | Routing scheme: 0 dimension order, 1 west-first, 2 north-last, 3 negative-first |
| credit_e | input | FW | Free buffer slots downstream of East |
| credit_w | input | FW | Free buffer slots downstream of West |
| credit_n | input | FW | Free buffer slots downstream of North |
| credit_s | input | FW | Free buffer slots downstream of South |
| route_vld | output | 1 | Registered route is fresh for the head flit of the previous cycle |
| route_port | output | 5 | One-hot output port |

## Verification
On every cycle, the in-line properties check these behaviours against the inputs of the previous cycle:
- the one-hot form of each fresh route and the holding of the port between head flits;
- Local delivery;
- minimality of the chosen port;
- the turn restriction of each of the four schemes.

The tie-breaking and credit comparison of the adaptive selector (R9) are shown only by the bench's scenarios. So is the exact port chosen when two are legal, since no property pins down which of two legal ports must win. The bench covers these by comparing every route with a behavioural model across directed corner cases and a large random sweep of coordinates, modes and credit counts.

// File: rtl/mesh_route_pkg.sv
package mesh_route_pkg;

    localparam int unsigned NPORT   = 5;
    localparam int unsigned P_LOCAL = 0;
    localparam int unsigned P_EAST  = 1;
    localparam int unsigned P_WEST  = 2;
    localparam int unsigned P_NORTH = 3;
    localparam int unsigned P_SOUTH = 4;

    typedef logic [NPORT-1:0] port_vec_t;

    typedef enum logic [1:0] {
        RM_DIM_ORDER  = 2'd0,
        RM_WEST_FIRST = 2'd1,
        RM_NORTH_LAST = 2'd2,
        RM_NEG_FIRST  = 2'd3
    } route_mode_e;

    typedef struct packed {
        logic      vld;
        port_vec_t port;
    } route_reg_t;

endpackage

// File: rtl/mesh_offset.sv
module mesh_offset #(
    parameter int unsigned CW = 3
) (
    input  logic [CW-1:0] here_x,
    input  logic [CW-1:0] here_y,
    input  logic [CW-1:0] dest_x,
    input  logic [CW-1:0] dest_y,
    output logic          go_east,
    output logic          go_west,
    output logic          go_north,
    output logic          go_south
);
    // Sign of each offset; unsigned compares keep the logic shallow.
    always_comb begin
        go_east  = dest_x > here_x;
        go_west  = dest_x < here_x;
        go_north = dest_y > here_y;
        go_south = dest_y < here_y;
    end
endmodule

// File: rtl/mesh_turn_filter.sv
module mesh_turn_filter
    import mesh_route_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       go_east,
    input  logic       go_west,
    input  logic       go_north,
    input  logic       go_south,
    output port_vec_t  allow
);
    route_mode_e mode_e;
    logic        arrived;
    logic        x_open;
    logic        neg_open;

    always_comb begin
        mode_e   = route_mode_e'(mode);
        arrived  = !(go_east || go_west || go_north || go_south);
        x_open   = go_east || go_west;
        neg_open = go_west || go_south;
        allow    = '0;
        unique case (mode_e)
            RM_DIM_ORDER: begin
                // Y is offered only once X is exhausted.
                allow[P_EAST]  = go_east;
                allow[P_WEST]  = go_west;
                allow[P_NORTH] = go_north && !x_open;
                allow[P_SOUTH] = go_south && !x_open;
            end
            RM_WEST_FIRST: begin
                // A westward leg must be taken before anything else.
                allow[P_WEST]  = go_west;
                allow[P_EAST]  = go_east;
                allow[P_NORTH] = go_north && !go_west;
                allow[P_SOUTH] = go_south && !go_west;
            end
            RM_NORTH_LAST: begin
                // North only when nothing else remains in X.
                allow[P_EAST]  = go_east;
                allow[P_WEST]  = go_west;
                allow[P_SOUTH] = go_south;
                allow[P_NORTH] = go_north && !x_open;
            end
            RM_NEG_FIRST: begin
                // Negative legs precede any positive leg.
                allow[P_WEST]  = go_west;
                allow[P_SOUTH] = go_south;
                allow[P_EAST]  = go_east && !neg_open;
                allow[P_NORTH] = go_north && !neg_open;
            end
            default: allow = '0;
        endcase
        allow[P_LOCAL] = arrived;
    end
endmodule

// File: rtl/mesh_port_select.sv
module mesh_port_select
    import mesh_route_pkg::*;
#(
    parameter int unsigned FW = 4
) (
    input  port_vec_t      allow,
    input  logic [FW-1:0]  credit_e,
    input  logic [FW-1:0]  credit_w,
    input  logic [FW-1:0]  credit_n,
    input  logic [FW-1:0]  credit_s,
    output port_vec_t      pick
);
    localparam port_vec_t X_MASK = port_vec_t'((1 << P_EAST) | (1 << P_WEST));
    localparam port_vec_t Y_MASK = port_vec_t'((1 << P_NORTH) | (1 << P_SOUTH));

    port_vec_t     x_part;
    port_vec_t     y_part;
    logic [FW-1:0] x_cred;
    logic [FW-1:0] y_cred;

    always_comb begin
        x_part = allow & X_MASK;
        y_part = allow & Y_MASK;
        x_cred = allow[P_EAST]  ? credit_e : credit_w;
        y_cred = allow[P_NORTH] ? credit_n : credit_s;
        if ((x_part != '0) && (y_part != '0)) begin
            // Strictly more room wins for Y; ties stay in X.
            pick = (y_cred > x_cred) ? y_part : x_part;
        end else begin
            pick = allow;
        end
    end
endmodule

// File: rtl/mesh_route_unit.sv
module mesh_route_unit
    import mesh_route_pkg::*;
#(
    parameter int unsigned CW = 3,
    parameter int unsigned FW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          head_vld,
    input  logic [CW-1:0] here_x,
    input  logic [CW-1:0] here_y,
    input  logic [CW-1:0] dest_x,
    input  logic [CW-1:0] dest_y,
    input  logic [1:0]    route_mode,
    input  logic [FW-1:0] credit_e,
    input  logic [FW-1:0] credit_w,
    input  logic [FW-1:0] credit_n,
    input  logic [FW-1:0] credit_s,
    output logic          route_vld,
    output logic [4:0]    route_port
);
    logic       go_east, go_west, go_north, go_south;
    port_vec_t  allow;
    port_vec_t  pick;
    route_reg_t st_d, st_q;

    mesh_offset #(.CW(CW)) u_offset (
        .here_x   (here_x),
        .here_y   (here_y),
        .dest_x   (dest_x),
        .dest_y   (dest_y),
        .go_east  (go_east),
        .go_west  (go_west),
        .go_north (go_north),
        .go_south (go_south)
    );

    mesh_turn_filter u_filter (
        .mode     (route_mode),
        .go_east  (go_east),
        .go_west  (go_west),
        .go_north (go_north),
        .go_south (go_south),
        .allow    (allow)
    );

    mesh_port_select #(.FW(FW)) u_select (
        .allow    (allow),
        .credit_e (credit_e),
        .credit_w (credit_w),
        .credit_n (credit_n),
        .credit_s (credit_s),
        .pick     (pick)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = head_vld;
        if (head_vld) begin
            st_d.port = pick;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign route_vld  = st_q.vld;
    assign route_port = st_q.port;

    // A fresh route always names exactly one port.
    assert_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        route_vld |-> ($countones(route_port) == 1));

    // Between head flits the registered port does not move.
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !head_vld |=> $stable(route_port));

    assert_local_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (route_vld && ($past(dest_x) == $past(here_x)) && ($past(dest_y) == $past(here_y)))
        |-> (route_port == 5'b00001));

    assert_minimal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        route_vld |->
            (!route_port[P_EAST]  || ($past(dest_x) > $past(here_x))) &&
            (!route_port[P_WEST]  || ($past(dest_x) < $past(here_x))) &&
            (!route_port[P_NORTH] || ($past(dest_y) > $past(here_y))) &&
            (!route_port[P_SOUTH] || ($past(dest_y) < $past(here_y))));

    assert_dim_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (route_vld && ($past(route_mode) == 2'd0) && ($past(dest_x) != $past(here_x)))
        |-> !(route_port[P_NORTH] || route_port[P_SOUTH]));

    assert_west_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (route_vld && ($past(route_mode) == 2'd1))
        |-> (route_port[P_WEST] == ($past(dest_x) < $past(here_x))));

    assert_north_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (route_vld && ($past(route_mode) == 2'd2) && route_port[P_NORTH])
        |-> ($past(dest_x) == $past(here_x)));

    assert_neg_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (route_vld && ($past(route_mode) == 2'd3) && (route_port[P_EAST] || route_port[P_NORTH]))
        |-> (($past(dest_x) >= $past(here_x)) && ($past(dest_y) >= $past(here_y))));

endmodule

// File: tb/sim_mesh_route_unit.sv
`timescale 1ns/1ps
module sim_mesh_route_unit;
    localparam int CW = 3;
    localparam int FW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          head_vld = 1'b0;
    logic [CW-1:0] here_x = '0, here_y = '0, dest_x = '0, dest_y = '0;
    logic [1:0]    route_mode = '0;
    logic [FW-1:0] credit_e = '0, credit_w = '0, credit_n = '0, credit_s = '0;
    logic          route_vld;
    logic [4:0]    route_port;

    int n_tests = 0;
    int n_fail  = 0;
    logic [4:0] last_port = '0;

    always #2.5 clk = ~clk;

    mesh_route_unit #(.CW(CW), .FW(FW)) u0 (
        .clk(clk), .rst_n(rst_n), .head_vld(head_vld),
        .here_x(here_x), .here_y(here_y), .dest_x(dest_x), .dest_y(dest_y),
        .route_mode(route_mode),
        .credit_e(credit_e), .credit_w(credit_w), .credit_n(credit_n), .credit_s(credit_s),
        .route_vld(route_vld), .route_port(route_port)
    );

    // Behavioural reference: list legal X and Y moves, then apply the credit rule.
    function automatic logic [4:0] ref_route(int m, int cx, int cy, int tx, int ty,
                                             int ce, int cwv, int cn, int cs);
        int dx = tx - cx;
        int dy = ty - cy;
        int xp = (dx > 0) ? 1 : ((dx < 0) ? 2 : -1);
        int yp = (dy > 0) ? 3 : ((dy < 0) ? 4 : -1);
        bit okx, oky, neg;
        int xc, yc;
        if (dx == 0 && dy == 0) return 5'b00001;
        case (m)
            0: begin okx = 1; oky = (xp < 0); end
            1: begin okx = 1; oky = !(dx < 0); end
            2: begin okx = 1; oky = (yp == 4) || (xp < 0); end
            default: begin
                neg = (dx < 0) || (dy < 0);
                okx = !neg || (dx < 0);
                oky = !neg || (dy < 0);
            end
        endcase
        okx = okx && (xp >= 0);
        oky = oky && (yp >= 0);
        xc = (xp == 1) ? ce : cwv;
        yc = (yp == 3) ? cn : cs;
        if (okx && oky) return (yc > xc) ? (5'b1 << yp) : (5'b1 << xp);
        if (okx) return 5'b1 << xp;
        return 5'b1 << yp;
    endfunction

    task automatic check(string tag, logic [4:0] act, logic [4:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic route(string tag, int m, int cx, int cy, int tx, int ty,
                         int ce, int cwv, int cn, int cs);
        logic [4:0] exp;
        @(negedge clk);
        head_vld = 1'b1; route_mode = m[1:0];
        here_x = cx[CW-1:0]; here_y = cy[CW-1:0]; dest_x = tx[CW-1:0]; dest_y = ty[CW-1:0];
        credit_e = ce[FW-1:0]; credit_w = cwv[FW-1:0]; credit_n = cn[FW-1:0]; credit_s = cs[FW-1:0];
        exp = ref_route(m, cx, cy, tx, ty, ce, cwv, cn, cs);
        @(negedge clk);
        check({tag, " vld"}, {4'b0, route_vld}, 5'b1);
        check(tag, route_port, exp);
        last_port = exp;
        head_vld = 1'b0;
    endtask

    function automatic string mode_tag(int m);
        case (m)
            0: return "R5";
            1: return "R6";
            2: return "R7";
            default: return "R8";
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset vld", {4'b0, route_vld}, 5'b0);
        check("R1 reset port", route_port, 5'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle vld", {4'b0, route_vld}, 5'b0);
        check("R1 idle port", route_port, 5'b0);

        // Local delivery in every mode
        for (int m = 0; m < 4; m++) route("R2 local", m, 3, 5, 3, 5, 1, 1, 1, 1);
        // Minimal single-axis moves
        route("R4 east",  0, 2, 2, 6, 2, 0, 0, 0, 0);
        route("R4 south", 0, 2, 6, 2, 1, 0, 0, 0, 0);
        // Dimension order: X first even when Y has more credit
        route("R5 x first", 0, 1, 1, 5, 6, 0, 0, 15, 15);
        route("R5 y after", 0, 5, 1, 5, 6, 0, 0, 3, 3);
        // West-first
        route("R6 west forced", 1, 6, 1, 2, 7, 0, 0, 15, 15);
        route("R6 adaptive n",  1, 1, 1, 4, 5, 2, 0, 9, 0);
        // North-last
        route("R7 x before north", 2, 1, 1, 4, 6, 0, 0, 15, 15);
        route("R7 north last",     2, 4, 1, 4, 6, 0, 0, 1, 0);
        route("R7 adaptive south", 2, 1, 6, 5, 2, 3, 0, 0, 8);
        // Negative-first
        route("R8 west before north", 3, 6, 1, 1, 6, 0, 0, 15, 0);
        route("R8 south before east", 3, 1, 6, 6, 1, 15, 0, 0, 0);
        route("R8 adaptive pos",      3, 1, 1, 6, 6, 4, 0, 7, 0);
        // Selector ties and strict wins
        route("R9 tie goes x",     1, 1, 1, 5, 5, 7, 0, 7, 0);
        route("R9 y strictly more",1, 1, 1, 5, 5, 6, 0, 7, 0);
        route("R9 x more",         3, 6, 6, 1, 1, 0, 9, 0, 2);
        check("R9 x more literal", route_port, 5'b00100);

        // No head flit: inputs change, route held and not flagged fresh
        @(negedge clk);
        head_vld = 1'b0; dest_x = 3'd0; dest_y = 3'd7; here_x = 3'd7; here_y = 3'd0;
        @(negedge clk);
        check("R3 no head vld", {4'b0, route_vld}, 5'b0);
        check("R3 held port", route_port, last_port);

        // Random sweep
        for (int i = 0; i < 2000; i++) begin
            int m = $urandom_range(0, 3);
            route(mode_tag(m), m, $urandom_range(0, 7), $urandom_range(0, 7),
                  $urandom_range(0, 7), $urandom_range(0, 7),
                  $urandom_range(0, 15), $urandom_range(0, 15),
                  $urandom_range(0, 15), $urandom_range(0, 15));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule